// File: doc/BRIEF.md
# Masked Sector Scan Comparator

This block searches one disk track for a sector that matches a search argument. The argument is a 256-byte pattern held in memory; any pattern byte equal to 0xFF is a don't-care and takes no part in the comparison. A scan command carries a control byte that selects one of three tests: equal, sector low-or-equal, or sector high-or-equal. The block then compares the sectors of the current track in order. It stops at the first sector that passes the selected test, or after the last sector of the track.

Sector bytes and pattern bytes arrive on two valid/ready byte streams that move in lockstep. One byte pair is taken per cycle, and only when both sides offer a byte. The block holds no copy of the pattern, so the pattern source must send the full pattern again for every sector, starting at its leftmost byte. Back-pressure rule: `sec_ready` is high only while a scan is running and `pat_valid` is high, and `pat_ready` is high only while a scan is running and `sec_valid` is high. A source whose valid is low stalls the other side. A source may raise valid without waiting for ready, and its valid must not depend on its ready. When the scan ends, both readies drop in the next cycle and the block accepts no further bytes.

The results are plain level outputs. `found` is the condition that software tests. `eq_hit` is the equal-hit status bit. `hit_sector` gives the index within the track of the sector that matched. All three hold their values until the next accepted scan command.

Top module: `sector_scan_cmp`

## Requirements
- R1: After reset, `busy`, `done`, `found`, `eq_hit`, `sec_ready` and `pat_ready` are all 0.
- R2: A `start` pulse while `busy` is 0 is accepted. In the next cycle `busy` is 1 and `done`, `found` and `eq_hit` are 0. A `start` while `busy` is 1 is ignored, and the running scan keeps its original mode.
- R3: A byte pair transfers only when `busy`, `sec_valid` and `pat_valid` are all 1. `sec_ready` equals `busy & pat_valid`, and `pat_ready` equals `busy & sec_valid`.
- R4: A pattern byte of 0xFF is excluded from the comparison, whatever the sector byte at that position holds.
- R5: The control byte `mode` selects the test: 0x01 passes a sector that is lower than or equal to the pattern, 0x02 passes a sector that is higher than or equal to the pattern, and every other value (including 0x00) passes only an equal sector.
- R6: The relation of a sector to the pattern is decided by the first unmasked byte pair that differs, counting from the first byte transferred. The comparison is unsigned (0xFF is higher than 0x33). If no unmasked pair differs, the sector is equal.
- R7: Each sector is exactly SECTOR_BYTES (default 256) byte pairs. Sectors are indexed from 0 in arrival order, and up to SECTORS (default 24) sectors make one track.
- R8: On the last byte of the first sector that passes, the scan stops. In the next cycle `busy` is 0, `done` and `found` are 1, and `hit_sector` holds that sector's index.
- R9: `eq_hit` is set together with `found` when the matching sector is equal to the pattern, in any mode. It stays 0 when the match was strictly lower or strictly higher.
- R10: If no sector of the track passes, the scan ends after the last byte of sector SECTORS-1 with `done` 1 and `found` and `eq_hit` 0.
- R11: After a scan ends, `done`, `found`, `eq_hit` and `hit_sector` hold their values, and both readies stay 0, until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Scan command pulse |
| mode | input | 8 | Control byte for the scan, sampled when `start` is accepted |
| sec_valid | input | 1 | Sector stream byte valid |
| sec_ready | output | 1 | Sector stream byte accepted |
| sec_data | input | 8 | Sector stream byte |
| pat_valid | input | 1 | Pattern stream byte valid |
| pat_ready | output | 1 | Pattern stream byte accepted |
| pat_data | input | 8 | Pattern stream byte |
| busy | output | 1 | Scan in progress |
| done | output | 1 | Last scan has ended |
| found | output | 1 | Last scan found a passing sector |
| eq_hit | output | 1 | Matching sector was equal to the pattern |
| hit_sector | output | 5 | Index of the matching sector within the track |

## Verification
The hardest case to reach is a `start` that arrives while a scan is part way through a sector. At the same moment one stream is stalled and the other still offers data. The result must show that the first control byte was kept and that no pair slipped through during the stall. The bench starts a low-or-equal scan and feeds a few bytes. It then pulses `start` with the high-or-equal code and holds the pattern side invalid for several cycles while the sector side stays valid. Sector 0 is built so that the two modes give different outcomes. The bench checks the readies during the stall and then checks the final result.

// File: rtl/sscan_pkg.sv
package sscan_pkg;

  typedef enum logic [1:0] {
    REL_EQ = 2'd0,
    REL_LT = 2'd1,
    REL_GT = 2'd2
  } rel_e;

  typedef enum logic [1:0] {
    TEST_EQ = 2'd0,
    TEST_LE = 2'd1,
    TEST_GE = 2'd2
  } test_e;

  function automatic test_e decode_test(input logic [7:0] ctl);
    case (ctl)
      8'h01:   decode_test = TEST_LE;
      8'h02:   decode_test = TEST_GE;
      default: decode_test = TEST_EQ;
    endcase
  endfunction

  function automatic logic test_passes(input test_e t, input rel_e r);
    case (t)
      TEST_LE: test_passes = (r == REL_EQ) || (r == REL_LT);
      TEST_GE: test_passes = (r == REL_EQ) || (r == REL_GT);
      default: test_passes = (r == REL_EQ);
    endcase
  endfunction

endpackage

// File: rtl/sscan_byte_judge.sv
module sscan_byte_judge
  import sscan_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] sec_byte,
  input  logic [DATA_W-1:0] pat_byte,
  input  rel_e              rel_in,
  output rel_e              rel_out
);

  localparam logic [DATA_W-1:0] DONT_CARE = '1;

  always_comb begin
    rel_out = rel_in;
    if (rel_in == REL_EQ && pat_byte != DONT_CARE) begin
      if (sec_byte < pat_byte)      rel_out = REL_LT;
      else if (sec_byte > pat_byte) rel_out = REL_GT;
    end
  end

endmodule

// File: rtl/sscan_walker.sv
module sscan_walker
  import sscan_pkg::*;
#(
  parameter int SECTOR_BYTES = 256,
  parameter int SECTORS      = 24,
  localparam int BYTE_W      = $clog2(SECTOR_BYTES),
  localparam int SEC_W       = $clog2(SECTORS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             step,
  input  rel_e             rel_next,
  output rel_e             rel_q,
  output logic             last_byte,
  output logic             last_sector,
  output logic [SEC_W-1:0] sector_idx
);

  localparam logic [BYTE_W-1:0] BYTE_LAST = BYTE_W'(SECTOR_BYTES - 1);
  localparam logic [SEC_W-1:0]  SEC_LAST  = SEC_W'(SECTORS - 1);

  logic [BYTE_W-1:0] byte_cnt;

  assign last_byte   = (byte_cnt == BYTE_LAST);
  assign last_sector = (sector_idx == SEC_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_cnt   <= '0;
      sector_idx <= '0;
      rel_q      <= REL_EQ;
    end else if (clear) begin
      byte_cnt   <= '0;
      sector_idx <= '0;
      rel_q      <= REL_EQ;
    end else if (step) begin
      if (last_byte) begin
        byte_cnt <= '0;
        rel_q    <= REL_EQ;
        if (!last_sector) sector_idx <= sector_idx + 1'b1;
      end else begin
        byte_cnt <= byte_cnt + 1'b1;
        rel_q    <= rel_next;
      end
    end
  end

  // R7: a sector boundary restarts the byte count and the running relation
  assert_sector_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (step && last_byte && !clear) |=> (byte_cnt == '0 && rel_q == REL_EQ));

  // R7: the byte count advances by one per accepted pair inside a sector
  assert_byte_advance_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !last_byte && !clear) |=> (byte_cnt == $past(byte_cnt) + 1'b1));

endmodule

// File: rtl/sector_scan_cmp.sv
module sector_scan_cmp
  import sscan_pkg::*;
#(
  parameter int DATA_W       = 8,
  parameter int SECTOR_BYTES = 256,
  parameter int SECTORS      = 24,
  localparam int SEC_W       = $clog2(SECTORS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [7:0]        mode,
  input  logic              sec_valid,
  output logic              sec_ready,
  input  logic [DATA_W-1:0] sec_data,
  input  logic              pat_valid,
  output logic              pat_ready,
  input  logic [DATA_W-1:0] pat_data,
  output logic              busy,
  output logic              done,
  output logic              found,
  output logic              eq_hit,
  output logic [SEC_W-1:0]  hit_sector
);

  test_e            test_q;
  rel_e             rel_q;
  rel_e             rel_next;
  logic             last_byte;
  logic             last_sector;
  logic [SEC_W-1:0] sector_idx;
  logic             accept;
  logic             xfer;
  logic             sector_end;
  logic             sector_pass;

  assign accept    = start && !busy;
  assign xfer      = busy && sec_valid && pat_valid;
  assign sec_ready = busy && pat_valid;
  assign pat_ready = busy && sec_valid;

  sscan_byte_judge #(.DATA_W(DATA_W)) u_judge (
    .sec_byte (sec_data),
    .pat_byte (pat_data),
    .rel_in   (rel_q),
    .rel_out  (rel_next)
  );

  sscan_walker #(.SECTOR_BYTES(SECTOR_BYTES), .SECTORS(SECTORS)) u_walker (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear       (accept),
    .step        (xfer),
    .rel_next    (rel_next),
    .rel_q       (rel_q),
    .last_byte   (last_byte),
    .last_sector (last_sector),
    .sector_idx  (sector_idx)
  );

  assign sector_end  = xfer && last_byte;
  assign sector_pass = test_passes(test_q, rel_next);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      done       <= 1'b0;
      found      <= 1'b0;
      eq_hit     <= 1'b0;
      hit_sector <= '0;
      test_q     <= TEST_EQ;
    end else if (accept) begin
      busy       <= 1'b1;
      done       <= 1'b0;
      found      <= 1'b0;
      eq_hit     <= 1'b0;
      hit_sector <= '0;
      test_q     <= decode_test(mode);
    end else if (sector_end) begin
      if (sector_pass) begin
        busy       <= 1'b0;
        done       <= 1'b1;
        found      <= 1'b1;
        eq_hit     <= (rel_next == REL_EQ);
        hit_sector <= sector_idx;
      end else if (last_sector) begin
        busy <= 1'b0;
        done <= 1'b1;
      end
    end
  end

  // R3: no byte is taken while no scan is running
  assert_idle_no_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!sec_ready && !pat_ready));

  // R2: an accepted command clears the previous outcome
  assert_start_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && !done && !found && !eq_hit));

  // R2: a command during a scan leaves the selected test untouched
  assert_busy_start_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(test_q));

  // R9: the equal-hit bit never stands without a match
  assert_eq_needs_found_R9: assert property (@(posedge clk) disable iff (!rst_n)
    eq_hit |-> found);

  // R8: a match always means the scan has ended
  assert_found_ended_R8: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> (done && !busy));

  // R11: outcome holds until a new command is accepted
  assert_hold_result_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> ($stable(found) && $stable(eq_hit) && $stable(hit_sector) && done));

endmodule

// File: tb/sector_scan_cmp_test.sv
module sector_scan_cmp_test;

  localparam int CLK_PERIOD = 10;
  localparam int NBYTES     = 256;
  localparam int NSEC       = 24;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [7:0] mode = 8'h00;
  logic       sec_valid = 1'b0;
  logic       sec_ready;
  logic [7:0] sec_data = 8'h00;
  logic       pat_valid = 1'b0;
  logic       pat_ready;
  logic [7:0] pat_data = 8'h00;
  logic       busy, done, found, eq_hit;
  logic [4:0] hit_sector;

  int checks = 0;
  int errors = 0;

  int p1 [NSEC];
  int v1 [NSEC];
  int p2 [NSEC];
  int v2 [NSEC];
  int cs, ci;

  always #(CLK_PERIOD/2) clk = ~clk;

  sector_scan_cmp uut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
    .sec_valid(sec_valid), .sec_ready(sec_ready), .sec_data(sec_data),
    .pat_valid(pat_valid), .pat_ready(pat_ready), .pat_data(pat_data),
    .busy(busy), .done(done), .found(found), .eq_hit(eq_hit),
    .hit_sector(hit_sector)
  );

  function automatic logic [7:0] pat_byte(input int i);
    if (i % 17 == 3) return 8'hFF;
    return 8'((i * 5 + 1) & 255);
  endfunction

  function automatic logic [7:0] sec_byte(input int s, input int i);
    if (i == p1[s]) return 8'(v1[s]);
    if (i == p2[s]) return 8'(v2[s]);
    if (pat_byte(i) == 8'hFF) return 8'((i * 13) & 255);
    return pat_byte(i);
  endfunction

  // relation from R4/R6: 0 equal, 1 lower, 2 higher
  function automatic int ref_rel(input int s);
    for (int i = 0; i < NBYTES; i++) begin
      if (pat_byte(i) != 8'hFF && sec_byte(s, i) != pat_byte(i))
        return (sec_byte(s, i) < pat_byte(i)) ? 1 : 2;
    end
    return 0;
  endfunction

  // R5 test selection
  function automatic logic ref_pass(input logic [7:0] m, input int r);
    if (m == 8'h01) return (r != 2);
    if (m == 8'h02) return (r != 1);
    return (r == 0);
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clear_sectors();
    for (int s = 0; s < NSEC; s++) begin
      p1[s] = -1; v1[s] = 0; p2[s] = -1; v2[s] = 0;
    end
  endtask

  task automatic issue_start(input logic [7:0] m);
    @(negedge clk);
    start = 1'b1;
    mode  = m;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    cs = 0;
    ci = 0;
  endtask

  // feeds up to n pairs, stops early when the scan ends; inputs change at negedge
  task automatic feed(input int n);
    for (int k = 0; k < n; k++) begin
      if (!busy) break;
      sec_valid = 1'b1;
      pat_valid = 1'b1;
      sec_data  = sec_byte(cs, ci);
      pat_data  = pat_byte(ci);
      @(posedge clk);
      ci++;
      if (ci == NBYTES) begin ci = 0; cs++; end
      @(negedge clk);
    end
    sec_valid = 1'b0;
    pat_valid = 1'b0;
  endtask

  task automatic check_result(input string req, input logic [7:0] m);
    int  exp_hit = -1;
    int  exp_rel = 0;
    for (int s = 0; s < NSEC; s++) begin
      if (exp_hit < 0 && ref_pass(m, ref_rel(s))) begin
        exp_hit = s;
        exp_rel = ref_rel(s);
      end
    end
    check(req, "busy", int'(busy), 0);
    check(req, "done", int'(done), 1);
    check(req, "found", int'(found), (exp_hit >= 0) ? 1 : 0);
    check(req, "eq_hit", int'(eq_hit), (exp_hit >= 0 && exp_rel == 0) ? 1 : 0);
    if (exp_hit >= 0) check(req, "hit_sector", int'(hit_sector), exp_hit);
  endtask

  task automatic t_reset();
    check("R1", "busy", int'(busy), 0);
    check("R1", "done", int'(done), 0);
    check("R1", "found", int'(found), 0);
    check("R1", "eq_hit", int'(eq_hit), 0);
    check("R1", "readies", int'({sec_ready, pat_ready}), 0);
  endtask

  task automatic t_equal_masked();
    clear_sectors();
    p1[0] = 10; v1[0] = 8'h00;
    p1[1] = 40; v1[1] = 8'hFF;
    p1[2] = 3;  v1[2] = 8'h00;
    p2[2] = 20; v2[2] = 8'h12;
    issue_start(8'h00);
    check("R2", "busy after start", int'(busy), 1);
    check("R2", "found cleared", int'(found), 0);
    feed(NSEC * NBYTES + 4);
    check_result("R4", 8'h00);
    check("R8", "hit_sector", int'(hit_sector), 2);
    check("R9", "eq_hit", int'(eq_hit), 1);
  endtask

  task automatic t_equal_none();
    clear_sectors();
    for (int s = 0; s < NSEC; s++) begin p1[s] = 200; v1[s] = 8'h00; end
    issue_start(8'h00);
    feed(NSEC * NBYTES + 4);
    check_result("R10", 8'h00);
    check("R10", "found", int'(found), 0);
  endtask

  task automatic t_low_first_diff();
    clear_sectors();
    p1[0] = 10; v1[0] = 8'hFF;
    p1[1] = 10; v1[1] = 8'h00;
    p2[1] = 40; v2[1] = 8'hFF;
    issue_start(8'h01);
    feed(NSEC * NBYTES + 4);
    check_result("R6", 8'h01);
    check("R5", "hit_sector", int'(hit_sector), 1);
    check("R9", "eq_hit strict", int'(eq_hit), 0);
  endtask

  task automatic t_high_unsigned();
    clear_sectors();
    p1[0] = 3;  v1[0] = 8'hFF;
    p2[0] = 10; v2[0] = 8'h00;
    p1[1] = 10; v1[1] = 8'hFF;
    issue_start(8'h02);
    feed(NSEC * NBYTES + 4);
    check_result("R6", 8'h02);
    check("R5", "hit_sector", int'(hit_sector), 1);
  endtask

  task automatic t_high_equal();
    clear_sectors();
    p1[0] = 20; v1[0] = 8'h00;
    issue_start(8'h02);
    feed(NSEC * NBYTES + 4);
    check_result("R9", 8'h02);
    check("R9", "eq_hit in ordered test", int'(eq_hit), 1);
    check("R8", "hit_sector", int'(hit_sector), 0);
  endtask

  task automatic t_other_code();
    clear_sectors();
    p1[0] = 10; v1[0] = 8'h00;
    issue_start(8'h07);
    feed(NSEC * NBYTES + 4);
    check_result("R5", 8'h07);
    check("R5", "code 0x07 acts as equal", int'(hit_sector), 1);
  endtask

  task automatic t_busy_start_and_stall();
    clear_sectors();
    p1[0] = 10; v1[0] = 8'h00;
    issue_start(8'h01);
    feed(5);
    start = 1'b1;
    mode  = 8'h02;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    check("R2", "busy kept", int'(busy), 1);
    sec_valid = 1'b1;
    pat_valid = 1'b0;
    sec_data  = 8'h00;
    for (int k = 0; k < 3; k++) begin
      #1;
      check("R3", "sec_ready in stall", int'(sec_ready), 0);
      check("R3", "pat_ready in stall", int'(pat_ready), 1);
      @(posedge clk);
      @(negedge clk);
    end
    sec_valid = 1'b0;
    feed(NSEC * NBYTES + 4);
    check_result("R2", 8'h01);
    check("R3", "hit after stall", int'(hit_sector), 0);
    // R11: offer bytes after the end; nothing is taken and the result holds
    sec_valid = 1'b1;
    pat_valid = 1'b1;
    for (int k = 0; k < 5; k++) begin
      @(posedge clk);
      @(negedge clk);
    end
    check("R11", "readies after end", int'({sec_ready, pat_ready}), 0);
    check("R11", "found held", int'(found), 1);
    check("R11", "hit_sector held", int'(hit_sector), 0);
    check("R11", "done held", int'(done), 1);
    sec_valid = 1'b0;
    pat_valid = 1'b0;
  endtask

  initial begin
    clear_sectors();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_equal_masked();
    t_equal_none();
    t_low_first_diff();
    t_high_unsigned();
    t_high_equal();
    t_other_code();
    t_busy_start_and_stall();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule